// File: doc/BRIEF.md
# Command-Triggered Transmit Holding Register

This block sits between a register port and a serial transmitter. Software places the next outgoing byte in a data register. Storing that byte does not start anything. A separate write to a command register does three things: it records a command byte, it drops the ready flag, and it raises a start request toward the shifter. The request stays up until the shifter pulses its load strobe, which is the cycle in which the shifter copies the byte. Ready then rises again.

The byte stays writable the whole time the request is pending. So the usual order (data, then command) and the order a DMA engine uses (command, then data) both hand the newest byte to the shifter. A read of the data register always returns the last byte written. Its contents after reset are not specified.

Top module: `txh_holding`

## Requirements
- R1: After reset, `ready_o` is 1 and `start_req_o` is 0.
- R2: A write to address 0 stores `wr_data_i` as the held byte, visible on `tx_data_o` in the next cycle. It leaves `start_req_o` and `ready_o` unchanged.
- R3: A write to address 1 stores the command byte on `tx_op_o`, and in the next cycle gives `start_req_o` = 1 and `ready_o` = 0.
- R4: While a request is pending, a write to address 0 replaces the held byte, and the shifter receives the latest byte written before its load strobe.
- R5: A load strobe while a request is pending gives `ready_o` = 1 and `start_req_o` = 0 in the next cycle. Until that strobe, the request stays asserted.
- R6: A read with `rd_addr_i` = 0 returns the last byte written to address 0, whether or not the shifter has taken it. A read with `rd_addr_i` = 1 returns the command byte.
- R7: When a load strobe and a write to address 0 fall in the same cycle, the shifter receives the previous byte, and the register holds the new byte afterwards.
- R8: A load strobe with no request pending has no effect: ready stays 1, the request stays 0, and the held byte is unchanged.
- R9: When a load strobe and a write to address 1 fall in the same cycle, the current byte is handed over and a new request is armed: `start_req_o` = 1 and `ready_o` = 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 1 | Write address: 0 data, 1 command |
| wr_data_i | input | W | Write data |
| rd_addr_i | input | 1 | Read address: 0 data, 1 command |
| rd_data_o | output | W | Read data (combinational) |
| load_i | input | 1 | Shifter load strobe, one cycle |
| start_req_o | output | 1 | Transmit request to the shifter |
| tx_data_o | output | W | Held byte presented to the shifter |
| tx_op_o | output | W | Command byte presented to the shifter |
| ready_o | output | 1 | Holding register free for a new command |

## Verification
Every cycle, the assertions check the effect of each kind of write on the request and ready flags, that a pending request persists until a load strobe, that a strobe releases it, and that a strobe with no request pending changes nothing. Only the bench's scenarios can show which byte the shifter actually receives: after an overwrite during a pending request, with the command written before the data, and when a strobe coincides with a data or command write. A scoreboard checks this byte against the expected value at each load strobe.

// File: rtl/txh_pkg.sv
`timescale 1ns/1ps
package txh_pkg;
    localparam int ADDR_W = 1;
    localparam logic [ADDR_W-1:0] DATA_ADDR = 1'b0;
    localparam logic [ADDR_W-1:0] OP_ADDR   = 1'b1;

    typedef struct packed {
        logic ready;
        logic req;
    } ctrl_t;
endpackage

// File: rtl/txh_wr_decode.sv
`timescale 1ns/1ps
module txh_wr_decode
    import txh_pkg::*;
(
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    output logic              data_we_o,
    output logic              op_we_o
);
    always_comb begin
        data_we_o = wr_en_i && (wr_addr_i == DATA_ADDR);
        op_we_o   = wr_en_i && (wr_addr_i == OP_ADDR);
    end
endmodule

// File: rtl/txh_ctrl.sv
`timescale 1ns/1ps
module txh_ctrl
    import txh_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic op_we_i,
    input  logic load_i,
    output logic req_o,
    output logic ready_o
);
    ctrl_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        // shifter takes the byte: release the request
        if (load_i && s_q.req) begin
            s_d.req   = 1'b0;
            s_d.ready = 1'b1;
        end
        // a command write arms a new attempt and wins over a release
        if (op_we_i) begin
            s_d.req   = 1'b1;
            s_d.ready = 1'b0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            s_q.ready <= 1'b1;
            s_q.req   <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign req_o   = s_q.req;
    assign ready_o = s_q.ready;
endmodule

// File: rtl/txh_hold_reg.sv
`timescale 1ns/1ps
module txh_hold_reg #(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         data_we_i,
    input  logic         op_we_i,
    input  logic [W-1:0] wr_data_i,
    output logic [W-1:0] data_o,
    output logic [W-1:0] op_o
);
    typedef struct packed {
        logic [W-1:0] data;
        logic [W-1:0] op;
    } hold_t;

    hold_t h_d, h_q;

    always_comb begin
        h_d = h_q;
        if (data_we_i) h_d.data = wr_data_i;
        if (op_we_i)   h_d.op   = wr_data_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            h_q <= '0;
        end else begin
            h_q <= h_d;
        end
    end

    assign data_o = h_q.data;
    assign op_o   = h_q.op;
endmodule

// File: rtl/txh_holding.sv
`timescale 1ns/1ps
module txh_holding
    import txh_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [W-1:0]      wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [W-1:0]      rd_data_o,
    input  logic              load_i,
    output logic              start_req_o,
    output logic [W-1:0]      tx_data_o,
    output logic [W-1:0]      tx_op_o,
    output logic              ready_o
);
    logic data_we, op_we;

    txh_wr_decode u_dec (
        .wr_en_i  (wr_en_i),
        .wr_addr_i(wr_addr_i),
        .data_we_o(data_we),
        .op_we_o  (op_we)
    );

    txh_ctrl u_ctrl (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .op_we_i(op_we),
        .load_i (load_i),
        .req_o  (start_req_o),
        .ready_o(ready_o)
    );

    txh_hold_reg #(.W(W)) u_hold (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .data_we_i(data_we),
        .op_we_i  (op_we),
        .wr_data_i(wr_data_i),
        .data_o   (tx_data_o),
        .op_o     (tx_op_o)
    );

    always_comb begin
        rd_data_o = (rd_addr_i == OP_ADDR) ? tx_op_o : tx_data_o;
    end
endmodule

// File: rtl/txh_holding_chk.sv
`timescale 1ns/1ps
module txh_holding_chk
    import txh_pkg::*;
#(
    parameter int W = 8
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              wr_en_i,
    input logic [ADDR_W-1:0] wr_addr_i,
    input logic [W-1:0]      wr_data_i,
    input logic              load_i,
    input logic              start_req_o,
    input logic [W-1:0]      tx_data_o,
    input logic              ready_o
);
    logic op_wr, data_wr;
    assign op_wr   = wr_en_i && (wr_addr_i == OP_ADDR);
    assign data_wr = wr_en_i && (wr_addr_i == DATA_ADDR);

    // R3 and R9: a command write arms the request
    a_r3_op_arms: assert property (@(posedge clk_i) disable iff (!rst_ni)
        op_wr |=> (start_req_o && !ready_o));

    // R2: a data write stores the byte and leaves the flags alone
    a_r2_data_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (data_wr && !load_i) |=> (tx_data_o == $past(wr_data_i)
            && start_req_o == $past(start_req_o) && ready_o == $past(ready_o)));

    // R5: the request persists until a load strobe
    a_r5_req_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_req_o && !load_i) |=> start_req_o);

    // R5: a load strobe releases a pending request
    a_r5_load_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_req_o && load_i && !op_wr) |=> (ready_o && !start_req_o));

    // R8: a strobe with no request pending changes nothing
    a_r8_idle_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!start_req_o && load_i && !wr_en_i) |=>
            (ready_o && !start_req_o && $stable(tx_data_o)));
endmodule

bind txh_holding txh_holding_chk #(.W(W)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .load_i     (load_i),
    .start_req_o(start_req_o),
    .tx_data_o  (tx_data_o),
    .ready_o    (ready_o)
);

// File: tb/tb_txh_holding.sv
`timescale 1ns/1ps
module tb_txh_holding;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [0:0]   wr_addr = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic [0:0]   rd_addr = 1'b0;
    logic [W-1:0] rd_data;
    logic         load = 1'b0;
    logic         start_req;
    logic [W-1:0] tx_data;
    logic [W-1:0] tx_op;
    logic         ready;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [W-1:0] exp_q[$];

    always #4 clk = ~clk;

    txh_holding #(.W(W)) dut (
        .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
        .load_i(load), .start_req_o(start_req), .tx_data_o(tx_data),
        .tx_op_o(tx_op), .ready_o(ready)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one cycle of stimulus; exp_byte is pushed when a handover is expected
    task automatic drive(input logic we, input logic a, input logic [W-1:0] d,
                         input logic ld, input logic push, input logic [W-1:0] exp_byte);
        wr_en = we; wr_addr = a; wr_data = d; load = ld;
        if (push) exp_q.push_back(exp_byte);
        @(negedge clk);
        wr_en = 1'b0; load = 1'b0;
    endtask

    task automatic flags(input string req, input logic r, input logic q);
        check(req, {7'd0, ready}, {7'd0, r});
        check(req, {7'd0, start_req}, {7'd0, q});
    endtask

    task automatic rd(input string req, input logic a, input logic [W-1:0] exp);
        rd_addr = a; #1;
        check(req, rd_data, exp);
    endtask

    // monitor: compares the byte the shifter takes at each pending load strobe
    initial begin
        forever begin
            @(negedge clk); #2;
            if (load && start_req) begin
                if (exp_q.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R4: unexpected handover actual %h expected none", tx_data);
                end else begin
                    check("R4/R7 handover", tx_data, exp_q.pop_front());
                end
            end
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        flags("R1 reset", 1'b1, 1'b0);

        drive(1, 0, 8'hA5, 0, 0, 0);
        flags("R2 data write", 1'b1, 1'b0);
        rd("R6 read data", 0, 8'hA5);

        drive(1, 1, 8'h3C, 0, 0, 0);
        flags("R3 command", 1'b0, 1'b1);
        check("R3 command byte", tx_op, 8'h3C);
        rd("R6 read command", 1, 8'h3C);

        drive(1, 0, 8'h5A, 0, 0, 0);
        flags("R4 overwrite pending", 1'b0, 1'b1);
        rd("R4 overwrite", 0, 8'h5A);
        drive(0, 0, 0, 0, 0, 0);
        flags("R5 held", 1'b0, 1'b1);

        drive(0, 0, 0, 1, 1, 8'h5A);
        flags("R5 release", 1'b1, 1'b0);
        rd("R6 after load", 0, 8'h5A);

        drive(0, 0, 0, 1, 0, 0);
        flags("R8 idle load", 1'b1, 1'b0);
        rd("R8 byte kept", 0, 8'h5A);

        // command first, then data
        drive(1, 1, 8'h11, 0, 0, 0);
        drive(1, 0, 8'hC3, 0, 0, 0);
        drive(0, 0, 0, 1, 1, 8'hC3);
        flags("R4 reversed order", 1'b1, 1'b0);

        // load and data write together
        drive(1, 0, 8'h77, 0, 0, 0);
        drive(1, 1, 8'h02, 0, 0, 0);
        drive(1, 0, 8'h88, 1, 1, 8'h77);
        flags("R7 flags", 1'b1, 1'b0);
        rd("R7 new byte", 0, 8'h88);

        // load and command write together
        drive(1, 0, 8'h21, 0, 0, 0);
        drive(1, 1, 8'h01, 0, 0, 0);
        drive(1, 1, 8'h02, 1, 1, 8'h21);
        flags("R9 rearmed", 1'b0, 1'b1);
        check("R9 command byte", tx_op, 8'h02);
        drive(0, 0, 0, 1, 1, 8'h21);
        flags("R9 second release", 1'b1, 1'b0);

        check("R4 queue drained", 8'(exp_q.size()), 8'd0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule